// File: doc/BRIEF.md
# Address Window Match Decoder

The block sits at the outgoing address port of a DMA engine and decides which target memory region each request falls into. It holds a set of programmable windows. Each window has an enable bit, two access-right bits, a base address and a size mask counted in 64 KB granules. Each base register also carries an 8-bit target attribute that tells the fabric which device the request addresses.

Each request address is compared against every enabled window at the same time. The lowest-numbered matching window is chosen. One cycle later the block reports:
- whether a window matched,
- which window matched,
- that window's attribute,
- whether the access may be forwarded, or was refused for lack of the right for its direction.

An address that matches no enabled window raises a decode-error flag and carries no attribute. An override register can pin every request to one window regardless of its address. Writing zero to the override register returns the block to address decoding.

Top module: `addr_window_decoder`

## Requirements
- R1: After reset every window is disabled and the override is off, so the first request after reset reports a decode error. The response flags are low while no response is due.
- R2: Bit i of the control register (select 0) enables window i. A window whose enable bit is clear never matches.
- R3: Window i matches when bits [31:16] of the address equal bits [31:16] of its base register in every bit position where its size register bits [31:16] hold 0. The size register holds (size/64 KB)-1 in bits [31:16], so the window covers a power-of-two multiple of 64 KB aligned to its size.
- R4: When several enabled windows match, the response names the lowest-numbered one.
- R5: A request that matches no window sets rsp_derr. In that case rsp_hit and rsp_fwd are low, rsp_attr is 0x00 and rsp_win is 0.
- R6: On a match, rsp_attr equals bits [15:8] of the chosen window's base register, and rsp_win equals its index.
- R7: Control bit 16+2i grants read and bit 17+2i grants write for window i, so 0b11 grants full access. A matched request whose direction lacks its right sets rsp_perr and keeps rsp_fwd low. Otherwise rsp_fwd is high.
- R8: The override register (select 1) forces every request onto window ovr[2:0] when bit 31 is set and that window is enabled. Writing 0 to it restores address decoding.
- R9: The response for a request presented in cycle n appears in cycle n+1 with rsp_valid high. A cycle without a request gives rsp_valid low and all flags low.
- R10: Register selects use the following encoding: 0 is control, 1 is override, 0x10+i is base i, 0x18+i is size i. A register takes effect for requests in the cycle after it is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_sel | input | 5 | Register select |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Request address |
| req_write | input | 1 | Request is a write |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | A window matched |
| rsp_win | output | 3 | Index of the chosen window |
| rsp_attr | output | 8 | Target attribute of the chosen window |
| rsp_fwd | output | 1 | Access allowed and forwarded |
| rsp_derr | output | 1 | No window matched |
| rsp_perr | output | 1 | Access right missing |

## Verification
The test programs four equal 256 MB memory windows, a 1 MB on-chip memory window, and a 16 MB window that overlaps the on-chip memory window. Addresses on the last and first granule of a window separate a correct size mask from an off-by-one mask. Addresses inside the overlap separate lowest-index priority from any other order. Read and write requests to a read-only window show that each direction uses its own permission bit. Clearing one enable bit, then setting and clearing the override, shows that a window drops out of decoding and that decoding is restored afterwards.

// File: rtl/awd_pkg.sv
package awd_pkg;
  localparam int ATTR_W    = 8;
  localparam int ATTR_LSB  = 8;
  localparam int PERM_LSB  = 16;
  localparam int OVR_EN_B  = 31;
  // register select groups (upper two bits of the select)
  localparam logic [1:0] GRP_MISC = 2'b00;
  localparam logic [1:0] GRP_BASE = 2'b10;
  localparam logic [1:0] GRP_SIZE = 2'b11;

  typedef enum logic [1:0] {
    PERM_NONE  = 2'b00,
    PERM_READ  = 2'b01,
    PERM_WRITE = 2'b10,
    PERM_FULL  = 2'b11
  } perm_e;
endpackage

// File: rtl/awd_regfile.sv
module awd_regfile #(
  parameter int NUM_WIN = 8,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 3,
  parameter int SEL_W   = IDX_W + 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [SEL_W-1:0]               wr_sel,
  input  logic [DATA_W-1:0]              wr_data,
  output logic [DATA_W-1:0]              ctrl_q,
  output logic [DATA_W-1:0]              ovr_q,
  output logic [NUM_WIN-1:0][DATA_W-1:0] base_q,
  output logic [NUM_WIN-1:0][DATA_W-1:0] size_q
);
  import awd_pkg::*;

  logic [1:0]       grp;
  logic [IDX_W-1:0] sub;
  assign grp = wr_sel[SEL_W-1 -: 2];
  assign sub = wr_sel[IDX_W-1:0];

  logic ctrl_we, ovr_we;
  logic [DATA_W-1:0] ctrl_d, ovr_d;

  always_comb begin
    ctrl_we = wr_en && (grp == GRP_MISC) && (sub == IDX_W'(0));
    ovr_we  = wr_en && (grp == GRP_MISC) && (sub == IDX_W'(1));
    ctrl_d  = ctrl_we ? wr_data : ctrl_q;
    ovr_d   = ovr_we  ? wr_data : ovr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ovr_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      ovr_q  <= ovr_d;
    end
  end

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    logic base_we, size_we;
    logic [DATA_W-1:0] base_d, size_d;
    always_comb begin
      base_we = wr_en && (grp == GRP_BASE) && (sub == IDX_W'(i));
      size_we = wr_en && (grp == GRP_SIZE) && (sub == IDX_W'(i));
      base_d  = base_we ? wr_data : base_q[i];
      size_d  = size_we ? wr_data : size_q[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[i] <= '0;
        size_q[i] <= '0;
      end else begin
        base_q[i] <= base_d;
        size_q[i] <= size_d;
      end
    end
  end
endmodule

// File: rtl/awd_match.sv
module awd_match #(
  parameter int NUM_WIN   = 8,
  parameter int ADDR_W    = 32,
  parameter int GRAN_LOG2 = 16,
  parameter int IDX_W     = 3
) (
  input  logic [ADDR_W-1:0]              addr,
  input  logic [NUM_WIN-1:0]             win_en,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0] base,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0] size,
  input  logic                           ovr_on,
  input  logic [IDX_W-1:0]               ovr_idx,
  output logic [NUM_WIN-1:0]             cand
);
  localparam int PAGE_W = ADDR_W - GRAN_LOG2;

  logic [NUM_WIN-1:0] addr_hit;

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_cmp
    logic [PAGE_W-1:0] keep;
    assign keep        = ~size[i][ADDR_W-1:GRAN_LOG2];
    assign addr_hit[i] = ((addr[ADDR_W-1:GRAN_LOG2] ^ base[i][ADDR_W-1:GRAN_LOG2]) & keep) == '0;
  end

  always_comb begin
    if (ovr_on) begin
      cand = '0;
      for (int i = 0; i < NUM_WIN; i++)
        if (ovr_idx == IDX_W'(i)) cand[i] = win_en[i];
    end else begin
      cand = addr_hit & win_en;
    end
  end
endmodule

// File: rtl/awd_prio.sv
module awd_prio #(
  parameter int NUM_WIN = 8,
  parameter int IDX_W   = 3
) (
  input  logic [NUM_WIN-1:0] cand,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (!any && cand[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder #(
  parameter int NUM_WIN   = 8,
  parameter int ADDR_W    = 32,
  parameter int GRAN_LOG2 = 16,
  parameter int IDX_W     = $clog2(NUM_WIN),
  parameter int SEL_W     = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [IDX_W-1:0]  rsp_win,
  output logic [7:0]        rsp_attr,
  output logic              rsp_fwd,
  output logic              rsp_derr,
  output logic              rsp_perr
);
  import awd_pkg::*;

  localparam int DATA_W = 32;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [DATA_W-1:0]              ctrl_q, ovr_q;
  logic [NUM_WIN-1:0][DATA_W-1:0] base_q, size_q;

  awd_regfile #(.NUM_WIN(NUM_WIN), .DATA_W(DATA_W), .IDX_W(IDX_W), .SEL_W(SEL_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (cfg_wr_en),
    .wr_sel  (cfg_sel),
    .wr_data (cfg_wdata),
    .ctrl_q  (ctrl_q),
    .ovr_q   (ovr_q),
    .base_q  (base_q),
    .size_q  (size_q)
  );

  logic [NUM_WIN-1:0]             win_en;
  logic [NUM_WIN-1:0][ADDR_W-1:0] base_a, size_a;
  for (genvar i = 0; i < NUM_WIN; i++) begin : g_fan
    assign win_en[i] = ctrl_q[i];
    assign base_a[i] = base_q[i][ADDR_W-1:0];
    assign size_a[i] = size_q[i][ADDR_W-1:0];
  end

  logic [NUM_WIN-1:0] cand;
  awd_match #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2), .IDX_W(IDX_W)) u_match (
    .addr    (req_addr),
    .win_en  (win_en),
    .base    (base_a),
    .size    (size_a),
    .ovr_on  (ovr_q[OVR_EN_B]),
    .ovr_idx (ovr_q[IDX_W-1:0]),
    .cand    (cand)
  );

  logic             sel_any;
  logic [IDX_W-1:0] sel_idx;
  awd_prio #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_prio (
    .cand (cand),
    .any  (sel_any),
    .idx  (sel_idx)
  );

  // next-state of the response stage
  logic             valid_d, hit_d, fwd_d, derr_d, perr_d;
  logic [IDX_W-1:0] win_d;
  logic [7:0]       attr_d;
  perm_e            perm;
  logic             right;

  always_comb begin
    perm    = perm_e'(ctrl_q[PERM_LSB + 2*sel_idx +: 2]);
    right   = req_write ? perm[1] : perm[0];
    valid_d = req_valid;
    hit_d   = req_valid && sel_any;
    derr_d  = req_valid && !sel_any;
    fwd_d   = hit_d && right;
    perr_d  = hit_d && !right;
    win_d   = hit_d ? sel_idx : '0;
    attr_d  = hit_d ? base_q[sel_idx][ATTR_LSB +: ATTR_W] : '0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_win   <= '0;
      rsp_attr  <= '0;
      rsp_fwd   <= 1'b0;
      rsp_derr  <= 1'b0;
      rsp_perr  <= 1'b0;
    end else begin
      rsp_valid <= valid_d;
      rsp_hit   <= hit_d;
      rsp_win   <= win_d;
      rsp_attr  <= attr_d;
      rsp_fwd   <= fwd_d;
      rsp_derr  <= derr_d;
      rsp_perr  <= perr_d;
    end
  end
endmodule

// File: rtl/awd_checker.sv
module awd_checker #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic [IDX_W-1:0] rsp_win,
  input logic [7:0]       rsp_attr,
  input logic             rsp_fwd,
  input logic             rsp_derr,
  input logic             rsp_perr
);
  assert_resp_follows_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_hit || rsp_fwd || rsp_derr || rsp_perr));

  assert_miss_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_derr |-> (!rsp_hit && !rsp_fwd && rsp_attr == 8'h00 && rsp_win == '0));

  assert_one_outcome_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_hit, rsp_derr}) == 1);

  assert_perr_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_perr |-> (rsp_hit && !rsp_fwd));

  assert_fwd_needs_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fwd |-> (rsp_hit && !rsp_perr));
endmodule

bind addr_window_decoder awd_checker #(.IDX_W(IDX_W)) u_awd_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_win   (rsp_win),
  .rsp_attr  (rsp_attr),
  .rsp_fwd   (rsp_fwd),
  .rsp_derr  (rsp_derr),
  .rsp_perr  (rsp_perr)
);

// File: tb/addr_window_decoder_test.sv
`timescale 1ns/1ps
module addr_window_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr_en;
  logic [4:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic        req_valid;
  logic [31:0] req_addr;
  logic        req_write;
  logic        rsp_valid, rsp_hit, rsp_fwd, rsp_derr, rsp_perr;
  logic [2:0]  rsp_win;
  logic [7:0]  rsp_attr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  addr_window_decoder uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_win(rsp_win),
    .rsp_attr(rsp_attr), .rsp_fwd(rsp_fwd), .rsp_derr(rsp_derr), .rsp_perr(rsp_perr)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [4:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  // request in one cycle, response sampled at the next falling edge
  task automatic probe(input string tag, input logic [31:0] addr, input logic wr,
                       input logic e_hit, input logic [2:0] e_win, input logic [7:0] e_attr,
                       input logic e_fwd, input logic e_perr);
    @(negedge clk);
    req_valid = 1'b1; req_addr = addr; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    check(tag, "valid", 32'(rsp_valid), 32'd1);
    check(tag, "hit",   32'(rsp_hit),   32'(e_hit));
    check(tag, "derr",  32'(rsp_derr),  32'(!e_hit));
    check(tag, "win",   32'(rsp_win),   32'(e_win));
    check(tag, "attr",  32'(rsp_attr),  32'(e_attr));
    check(tag, "fwd",   32'(rsp_fwd),   32'(e_fwd));
    check(tag, "perr",  32'(rsp_perr),  32'(e_perr));
  endtask

  task automatic t_reset;
    check("R1", "valid after reset", 32'(rsp_valid), 32'd0);
    check("R1", "hit after reset",   32'(rsp_hit),   32'd0);
    probe("R1", 32'h0000_1000, 1'b0, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic t_program;
    // R10: select map 0 ctrl, 1 override, 0x10+i base, 0x18+i size
    reg_wr(5'h10, 32'h0000_0E00); reg_wr(5'h18, 32'h0FFF_0000);
    reg_wr(5'h11, 32'h1000_0D00); reg_wr(5'h19, 32'h0FFF_0000);
    reg_wr(5'h12, 32'h2000_0B00); reg_wr(5'h1A, 32'h0FFF_0000);
    reg_wr(5'h13, 32'h3000_0700); reg_wr(5'h1B, 32'h0FFF_0000);
    reg_wr(5'h14, 32'h4000_1F00); reg_wr(5'h1C, 32'h000F_0000);
    reg_wr(5'h15, 32'h4000_5500); reg_wr(5'h1D, 32'h00FF_0000);
    // enables 0..5, window 3 read-only, others full
    reg_wr(5'h00, 32'h0F7F_003F);
  endtask

  task automatic t_decode;
    probe("R6",  32'h1234_5678, 1'b0, 1'b1, 3'd1, 8'h0D, 1'b1, 1'b0);
    probe("R6",  32'h2000_0000, 1'b0, 1'b1, 3'd2, 8'h0B, 1'b1, 1'b0);
    probe("R3",  32'h0FFF_FFFF, 1'b1, 1'b1, 3'd0, 8'h0E, 1'b1, 1'b0);
    probe("R3",  32'h400F_FFFF, 1'b0, 1'b1, 3'd4, 8'h1F, 1'b1, 1'b0);
    probe("R3",  32'h4010_0000, 1'b0, 1'b1, 3'd5, 8'h55, 1'b1, 1'b0);
    probe("R5",  32'h5000_0000, 1'b0, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0);
    probe("R5",  32'h4100_0000, 1'b1, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic t_priority;
    probe("R4", 32'h4008_0000, 1'b0, 1'b1, 3'd4, 8'h1F, 1'b1, 1'b0);
    probe("R4", 32'h4000_0000, 1'b1, 1'b1, 3'd4, 8'h1F, 1'b1, 1'b0);
  endtask

  task automatic t_perm;
    probe("R7", 32'h3000_0040, 1'b1, 1'b1, 3'd3, 8'h07, 1'b0, 1'b1);
    probe("R7", 32'h3000_0040, 1'b0, 1'b1, 3'd3, 8'h07, 1'b1, 1'b0);
    probe("R7", 32'h1000_0000, 1'b1, 1'b1, 3'd1, 8'h0D, 1'b1, 1'b0);
  endtask

  task automatic t_enable;
    reg_wr(5'h00, 32'h0F7F_003D);
    probe("R2", 32'h1234_5678, 1'b0, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0);
    probe("R2", 32'h2000_0000, 1'b0, 1'b1, 3'd2, 8'h0B, 1'b1, 1'b0);
    reg_wr(5'h00, 32'h0F7F_003F);
    probe("R2", 32'h1234_5678, 1'b0, 1'b1, 3'd1, 8'h0D, 1'b1, 1'b0);
  endtask

  task automatic t_override;
    reg_wr(5'h01, 32'h8000_0001);
    probe("R8", 32'h4000_0000, 1'b0, 1'b1, 3'd1, 8'h0D, 1'b1, 1'b0);
    probe("R8", 32'h7000_0000, 1'b0, 1'b1, 3'd1, 8'h0D, 1'b1, 1'b0);
    reg_wr(5'h01, 32'h0000_0000);
    probe("R8", 32'h4000_0000, 1'b0, 1'b1, 3'd4, 8'h1F, 1'b1, 1'b0);
    probe("R8", 32'h7000_0000, 1'b0, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    @(negedge clk);
    check("R9", "valid idle", 32'(rsp_valid), 32'd0);
    check("R9", "flags idle", 32'({rsp_hit, rsp_fwd, rsp_derr, rsp_perr}), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    req_valid = 1'b0; req_addr = '0; req_write = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_program();
    t_decode();
    t_priority();
    t_perm();
    t_enable();
    t_override();
    t_idle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule